// File: doc/BRIEF.md
# Reset and Clock Domain Sequencer

This block owns the reset and clock-enable state of a chip right after any system reset, and it then walks a secondary output PLL through its bring-up under software control. Two reset sources feed it. A power-up reset clears everything, including the main PLL reset. A general reset request covers a power-good drop or a watchdog expiry; it clears everything except the main PLL, which keeps running. When either reset ends, only the processor and peripheral reset domains come out of reset on their own. Every other internal domain, the secondary PLL dividers and the external reset pins stay held until software releases them.

Software drives the block through a write-only register port with an address, data and a write strobe. Bring-up follows a fixed order. Software first programs the PLL rate while the PLL is still powered down. It then powers up the PLL, and the dividers stay in reset. It waits for a qualified lock and programs the output clock rate. After that it releases the divider resets, and last it releases the external resets. Any command issued out of this order is ignored. A divider release attempted without lock also sets a sticky error flag. The lock input passes through a synchronizer and must stay high for a run of consecutive cycles before it counts as lock.

Top module: `rst_clk_seq`

## Requirements
- R1: While either `por_n` or `sys_rst_n` is low, and after it returns high, the block holds its defaults until software changes them: `gpio_oe`, `fe_clk_en`, `proc_clk_div`, `disp_dout`, `disp_drive`, `ddr_rate`, `out_rate`, `seq_err` and `ext_rst_n` are all zero, `sec_pll_pd` is 1 and `sec_div_rst_n` is 0. A register write in a cycle where a reset is active is lost.
- R2: `main_pll_rst_n` goes low only while `por_n` is low. A low on `sys_rst_n` leaves it high.
- R3: Once reset ends, `dom_rst_n` bits 0 (processor) and 1 (peripheral) go high and all other bits stay low. A write to address 3 releases domain i when data bit i is 1 and holds it again when bit i is 0. Bits 0 and 1 always stay released.
- R4: Every reset output goes low at once, with no clock, when its reset cause appears. A domain reset goes high only after two edges of that domain's own clock.
- R5: A write to address 1 loads data[7:0] into `ddr_rate`, but only while `sec_pll_pd` is 1. At any other time the write is ignored.
- R6: A command write (address 0) with data bit 0 set, made while the PLL is powered down, drives `sec_pll_pd` to 0 and keeps `sec_div_rst_n` at 0.
- R7: `pll_lock` passes through two flops. `seq_locked` goes high only after the synchronized lock has been high for 16 consecutive cycles. Any low cycle restarts the count, and the count is held clear while the PLL is powered down.
- R8: A write to address 2 loads data[7:0] into `out_rate`, but only while `seq_locked` is 1 and the dividers are still in reset. At any other time the write is ignored.
- R9: A command write with data bit 1 set releases `sec_div_rst_n` when `seq_locked` is 1 and the PLL is powered up. When `seq_locked` is 0, the write is ignored and sets `seq_err`, which stays 1 until the next reset.
- R10: A command write with data bit 2 set drives every `ext_rst_n` bit high, but only once the dividers have been released. Before that the write is ignored.
- R11: A write to address 4 sets `fe_clk_en` from data[3:0]. Address 5 sets `gpio_oe` from data[7:0]. Address 6 sets `disp_dout` from data[7:0] and `disp_drive` from data bit 8. Address 7 sets `proc_clk_div` from data[2:0], where 0 means full rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| sys_rst_n | input | 1 | General reset request (power-good drop, watchdog), active low |
| dom_clk | input | N_DOM | One clock per internal reset domain |
| pll_lock | input | 1 | Raw lock indication from the secondary PLL |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| main_pll_rst_n | output | 1 | Main PLL reset, active low |
| dom_rst_n | output | N_DOM | Per-domain resets, active low |
| proc_clk_div | output | PDIV_W | Processor clock divider select, 0 = full rate |
| fe_clk_en | output | N_FE | Front-end clock enables |
| sec_pll_pd | output | 1 | Secondary PLL power-down |
| sec_div_rst_n | output | 1 | Secondary PLL divider reset, active low |
| ddr_rate | output | RATE_W | Programmed secondary PLL rate |
| out_rate | output | RATE_W | Programmed output clock rate |
| seq_locked | output | 1 | Qualified lock status |
| seq_err | output | 1 | Sticky sequence-error flag |
| gpio_oe | output | N_GPIO | GPIO output enables, 0 = high impedance |
| disp_dout | output | N_DISP | Display-interface output levels |
| disp_drive | output | 1 | Display output-enable pin drive, 0 = tri-state |
| ext_rst_n | output | N_EXT | External reset outputs, active low |

## Verification
Two events can land in the same clock cycle: a register write and a general reset request. The bench provokes this by dropping `sys_rst_n` in the very cycle that a GPIO enable write is strobed. It then requires that the reset wins, with `gpio_oe` and the rest of the sequencer state back at their defaults and `main_pll_rst_n` untouched. The lock qualifier is driven with a lock pulse shorter than the 16-cycle window and then with a sustained lock. Divider-release commands are issued on both sides of that boundary, so both the ignored-with-error path and the accepted path are observed at the ports.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

   // Sequencer phase of the secondary PLL bring-up
   typedef enum logic [1:0] {
      SQ_OFF     = 2'd0,   // PLL powered down, dividers in reset
      SQ_LOCKING = 2'd1,   // PLL powered, dividers held, waiting for lock
      SQ_RUN     = 2'd2,   // dividers released, external resets held
      SQ_UP      = 2'd3    // external resets released
   } seq_state_t;

   // Register addresses
   localparam int A_CMD    = 0;
   localparam int A_RATE   = 1;
   localparam int A_ORATE  = 2;
   localparam int A_DOMREL = 3;
   localparam int A_FE     = 4;
   localparam int A_GPIO   = 5;
   localparam int A_DISP   = 6;
   localparam int A_PDIV   = 7;

   // Command bit positions
   localparam int C_PLL_EN  = 0;
   localparam int C_DIV_REL = 1;
   localparam int C_EXT_REL = 2;

endpackage

// File: rtl/rcs_rst_sync.sv
module rcs_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_n_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rcs_rst_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         chain <= '0;
      end else begin
         chain <= {chain[STAGES-2:0], 1'b1};
      end
   end

   assign rst_n_o = chain[STAGES-1];

   // R4
   sync_release_chk: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(rst_n_o) |-> $past(arst_n));

endmodule

// File: rtl/rcs_lock_qual.sv
module rcs_lock_qual #(
   parameter int SYNC_STAGES = 2,
   parameter int LOCK_CNT    = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic lock_raw,
   output logic locked
);

   localparam int CNT_W = $clog2(LOCK_CNT + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("rcs_lock_qual: SYNC_STAGES must be at least 2");
      end
      if (LOCK_CNT < 1) begin : g_bad_cnt
         $error("rcs_lock_qual: LOCK_CNT must be at least 1");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   lk_s;
   logic [CNT_W-1:0]       cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], lock_raw};
      end
   end

   assign lk_s = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear || !lk_s) begin
         cnt_q <= '0;
      end else if (cnt_q != CNT_W'(LOCK_CNT)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign locked = (cnt_q == CNT_W'(LOCK_CNT));

   // R7
   lock_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> $past(lk_s));

   // R7
   lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clear) |-> !locked);

endmodule

// File: rtl/rcs_seq_ctrl.sv
module rcs_seq_ctrl
   import rcs_pkg::*;
#(
   parameter int              ADDR_W   = 4,
   parameter int              DATA_W   = 16,
   parameter int              N_DOM    = 6,
   parameter logic [N_DOM-1:0] DOM_AUTO = 6'b000011,
   parameter int              N_FE     = 4,
   parameter int              N_GPIO   = 8,
   parameter int              N_DISP   = 8,
   parameter int              N_EXT    = 2,
   parameter int              RATE_W   = 8,
   parameter int              PDIV_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              locked,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [N_DOM-1:0]  dom_rel,
   output logic [PDIV_W-1:0] proc_clk_div,
   output logic [N_FE-1:0]   fe_clk_en,
   output logic              sec_pll_pd,
   output logic              sec_div_rst_n,
   output logic [RATE_W-1:0] ddr_rate,
   output logic [RATE_W-1:0] out_rate,
   output logic              seq_err,
   output logic [N_GPIO-1:0] gpio_oe,
   output logic [N_DISP-1:0] disp_dout,
   output logic              disp_drive,
   output logic [N_EXT-1:0]  ext_rst_n
);

   generate
      if (N_DISP + 1 > DATA_W) begin : g_bad_disp
         $error("rcs_seq_ctrl: N_DISP+1 exceeds DATA_W");
      end
      if (N_GPIO > DATA_W || N_FE > DATA_W || N_DOM > DATA_W) begin : g_bad_width
         $error("rcs_seq_ctrl: a field is wider than DATA_W");
      end
      if (RATE_W > DATA_W || PDIV_W > DATA_W || C_EXT_REL >= DATA_W) begin : g_bad_rate
         $error("rcs_seq_ctrl: rate, divider or command field exceeds DATA_W");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("rcs_seq_ctrl: ADDR_W too small for the register map");
      end
   endgenerate

   seq_state_t state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= SQ_OFF;
         seq_err      <= 1'b0;
         ddr_rate     <= '0;
         out_rate     <= '0;
         dom_rel      <= DOM_AUTO;
         fe_clk_en    <= '0;
         gpio_oe      <= '0;
         disp_dout    <= '0;
         disp_drive   <= 1'b0;
         proc_clk_div <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            ADDR_W'(A_CMD): begin
               if (reg_wdata[C_PLL_EN] && state_q == SQ_OFF) begin
                  state_q <= SQ_LOCKING;
               end
               if (reg_wdata[C_DIV_REL]) begin
                  if (!locked) begin
                     seq_err <= 1'b1;
                  end else if (state_q == SQ_LOCKING) begin
                     state_q <= SQ_RUN;
                  end
               end
               if (reg_wdata[C_EXT_REL] && state_q == SQ_RUN) begin
                  state_q <= SQ_UP;
               end
            end
            ADDR_W'(A_RATE): begin
               if (state_q == SQ_OFF) begin
                  ddr_rate <= reg_wdata[RATE_W-1:0];
               end
            end
            ADDR_W'(A_ORATE): begin
               if (state_q == SQ_LOCKING && locked) begin
                  out_rate <= reg_wdata[RATE_W-1:0];
               end
            end
            ADDR_W'(A_DOMREL): dom_rel      <= reg_wdata[N_DOM-1:0] | DOM_AUTO;
            ADDR_W'(A_FE):     fe_clk_en    <= reg_wdata[N_FE-1:0];
            ADDR_W'(A_GPIO):   gpio_oe      <= reg_wdata[N_GPIO-1:0];
            ADDR_W'(A_DISP): begin
               disp_dout  <= reg_wdata[N_DISP-1:0];
               disp_drive <= reg_wdata[N_DISP];
            end
            ADDR_W'(A_PDIV):   proc_clk_div <= reg_wdata[PDIV_W-1:0];
            default: ;
         endcase
      end
   end

   assign sec_pll_pd    = (state_q == SQ_OFF);
   assign sec_div_rst_n = (state_q == SQ_RUN) || (state_q == SQ_UP);
   assign ext_rst_n     = {N_EXT{state_q == SQ_UP}};

   // R9
   div_release_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sec_div_rst_n) |-> $past(locked));

   // R9
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |=> seq_err);

   // R10
   ext_after_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_rst_n[0]) |-> $past(sec_div_rst_n));

   // R6
   power_up_holds_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sec_pll_pd) |-> !sec_div_rst_n);

   // R5
   rate_only_when_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ddr_rate) |-> $past(sec_pll_pd));

   // R8
   orate_only_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(out_rate) |-> ($past(locked) && !$past(sec_div_rst_n)));

endmodule

// File: rtl/rst_clk_seq.sv
module rst_clk_seq #(
   parameter int               ADDR_W      = 4,
   parameter int               DATA_W      = 16,
   parameter int               N_DOM       = 6,
   parameter logic [N_DOM-1:0] DOM_AUTO    = 6'b000011,
   parameter int               N_FE        = 4,
   parameter int               N_GPIO      = 8,
   parameter int               N_DISP      = 8,
   parameter int               N_EXT       = 2,
   parameter int               RATE_W      = 8,
   parameter int               PDIV_W      = 3,
   parameter int               SYNC_STAGES = 2,
   parameter int               LOCK_CNT    = 16
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic [N_DOM-1:0]  dom_clk,
   input  logic              pll_lock,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic              main_pll_rst_n,
   output logic [N_DOM-1:0]  dom_rst_n,
   output logic [PDIV_W-1:0] proc_clk_div,
   output logic [N_FE-1:0]   fe_clk_en,
   output logic              sec_pll_pd,
   output logic              sec_div_rst_n,
   output logic [RATE_W-1:0] ddr_rate,
   output logic [RATE_W-1:0] out_rate,
   output logic              seq_locked,
   output logic              seq_err,
   output logic [N_GPIO-1:0] gpio_oe,
   output logic [N_DISP-1:0] disp_dout,
   output logic              disp_drive,
   output logic [N_EXT-1:0]  ext_rst_n
);

   generate
      if (N_DOM < 2) begin : g_bad_dom
         $error("rst_clk_seq: at least processor and peripheral domains needed");
      end
   endgenerate

   logic             any_rst_n;
   logic             core_rst_n;
   logic [N_DOM-1:0] dom_rel;

   assign any_rst_n = por_n & sys_rst_n;

   // Main PLL reset follows the power-up reset alone
   rcs_rst_sync #(.STAGES(SYNC_STAGES)) u_main_sync (
      .clk     (clk),
      .arst_n  (por_n),
      .rst_n_o (main_pll_rst_n)
   );

   // Sequencer core reset follows every reset source
   rcs_rst_sync #(.STAGES(SYNC_STAGES)) u_core_sync (
      .clk     (clk),
      .arst_n  (any_rst_n),
      .rst_n_o (core_rst_n)
   );

   rcs_lock_qual #(
      .SYNC_STAGES (SYNC_STAGES),
      .LOCK_CNT    (LOCK_CNT)
   ) u_lock (
      .clk      (clk),
      .rst_n    (core_rst_n),
      .clear    (sec_pll_pd),
      .lock_raw (pll_lock),
      .locked   (seq_locked)
   );

   rcs_seq_ctrl #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .N_DOM    (N_DOM),
      .DOM_AUTO (DOM_AUTO),
      .N_FE     (N_FE),
      .N_GPIO   (N_GPIO),
      .N_DISP   (N_DISP),
      .N_EXT    (N_EXT),
      .RATE_W   (RATE_W),
      .PDIV_W   (PDIV_W)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (core_rst_n),
      .locked        (seq_locked),
      .reg_wr        (reg_wr),
      .reg_addr      (reg_addr),
      .reg_wdata     (reg_wdata),
      .dom_rel       (dom_rel),
      .proc_clk_div  (proc_clk_div),
      .fe_clk_en     (fe_clk_en),
      .sec_pll_pd    (sec_pll_pd),
      .sec_div_rst_n (sec_div_rst_n),
      .ddr_rate      (ddr_rate),
      .out_rate      (out_rate),
      .seq_err       (seq_err),
      .gpio_oe       (gpio_oe),
      .disp_dout     (disp_dout),
      .disp_drive    (disp_drive),
      .ext_rst_n     (ext_rst_n)
   );

   // One synchronizer per domain, clocked by that domain
   generate
      for (genvar gi = 0; gi < N_DOM; gi++) begin : g_dom
         rcs_rst_sync #(.STAGES(SYNC_STAGES)) u_dom_sync (
            .clk     (dom_clk[gi]),
            .arst_n  (core_rst_n & dom_rel[gi]),
            .rst_n_o (dom_rst_n[gi])
         );
      end
   endgenerate

   // R2
   main_pll_por_only_chk: assert property (@(posedge clk) disable iff (!por_n)
      $past(por_n) |-> main_pll_rst_n || !$past(main_pll_rst_n));

   // R4
   core_reset_holds_dom_chk: assert property (@(posedge clk) disable iff (!por_n)
      !core_rst_n |-> (dom_rst_n == '0));

endmodule

// File: tb/test_rst_clk_seq.sv
module test_rst_clk_seq;

   localparam int CLK_P = 10;
   localparam int N_DOM = 6;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        sys_rst_n = 1'b1;
   logic        pll_lock = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;

   logic        main_pll_rst_n;
   logic [5:0]  dom_rst_n;
   logic [2:0]  proc_clk_div;
   logic [3:0]  fe_clk_en;
   logic        sec_pll_pd;
   logic        sec_div_rst_n;
   logic [7:0]  ddr_rate;
   logic [7:0]  out_rate;
   logic        seq_locked;
   logic        seq_err;
   logic [7:0]  gpio_oe;
   logic [7:0]  disp_dout;
   logic        disp_drive;
   logic [1:0]  ext_rst_n;

   always #(CLK_P/2) clk = ~clk;

   rst_clk_seq i_rst_clk_seq (
      .clk            (clk),
      .por_n          (por_n),
      .sys_rst_n      (sys_rst_n),
      .dom_clk        ({N_DOM{clk}}),
      .pll_lock       (pll_lock),
      .reg_wr         (reg_wr),
      .reg_addr       (reg_addr),
      .reg_wdata      (reg_wdata),
      .main_pll_rst_n (main_pll_rst_n),
      .dom_rst_n      (dom_rst_n),
      .proc_clk_div   (proc_clk_div),
      .fe_clk_en      (fe_clk_en),
      .sec_pll_pd     (sec_pll_pd),
      .sec_div_rst_n  (sec_div_rst_n),
      .ddr_rate       (ddr_rate),
      .out_rate       (out_rate),
      .seq_locked     (seq_locked),
      .seq_err        (seq_err),
      .gpio_oe        (gpio_oe),
      .disp_dout      (disp_dout),
      .disp_drive     (disp_drive),
      .ext_rst_n      (ext_rst_n)
   );

   // Output selectors for the scoreboard
   localparam int S_GPIO = 0,  S_FE = 1,   S_DOUT = 2,  S_DRV = 3,  S_PDIV = 4;
   localparam int S_PD = 5,    S_DIV = 6,  S_RATE = 7,  S_ORATE = 8;
   localparam int S_LOCK = 9,  S_ERR = 10, S_EXT = 11,  S_DOM = 12, S_MAIN = 13;

   typedef struct {
      string       tag;
      int          sel;
      logic [31:0] exp;
   } item_t;

   item_t q[$];
   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   function automatic logic [31:0] probe(int sel);
      case (sel)
         S_GPIO:  return 32'(gpio_oe);
         S_FE:    return 32'(fe_clk_en);
         S_DOUT:  return 32'(disp_dout);
         S_DRV:   return 32'(disp_drive);
         S_PDIV:  return 32'(proc_clk_div);
         S_PD:    return 32'(sec_pll_pd);
         S_DIV:   return 32'(sec_div_rst_n);
         S_RATE:  return 32'(ddr_rate);
         S_ORATE: return 32'(out_rate);
         S_LOCK:  return 32'(seq_locked);
         S_ERR:   return 32'(seq_err);
         S_EXT:   return 32'(ext_rst_n);
         S_DOM:   return 32'(dom_rst_n);
         S_MAIN:  return 32'(main_pll_rst_n);
         default: return 32'hDEAD_BEEF;
      endcase
   endfunction

   // Monitor: compares queued expectations a quarter period after each edge
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_P/4);
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = probe(it.sel);
            n_checks++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
            end
         end
      end
   end

   task automatic expect_out(string tag, int sel, logic [31:0] exp);
      item_t it;
      it.tag = tag;
      it.sel = sel;
      it.exp = exp;
      q.push_back(it);
   endtask

   task automatic settle();
      wait (q.size() == 0);
      @(negedge clk);
   endtask

   task automatic wr_reg(logic [3:0] a, logic [15:0] d);
      @(negedge clk);
      reg_wr    = 1'b1;
      reg_addr  = a;
      reg_wdata = d;
      @(negedge clk);
      reg_wr    = 1'b0;
      reg_wdata = '0;
      repeat (3) @(negedge clk);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_defaults(string tag);
      expect_out(tag, S_GPIO, 0);
      expect_out(tag, S_FE, 0);
      expect_out(tag, S_DOUT, 0);
      expect_out(tag, S_DRV, 0);
      expect_out(tag, S_PDIV, 0);
      expect_out(tag, S_PD, 1);
      expect_out(tag, S_DIV, 0);
      expect_out(tag, S_RATE, 0);
      expect_out(tag, S_ORATE, 0);
      expect_out(tag, S_ERR, 0);
      expect_out(tag, S_EXT, 0);
      settle();
   endtask

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   // Driver
   initial begin
      // Power-up reset in progress: R4, R2
      idle(3);
      expect_out("R4 dom resets low during power-up reset", S_DOM, 0);
      expect_out("R2 main PLL reset low during power-up reset", S_MAIN, 0);
      settle();

      por_n = 1'b1;
      idle(8);
      check_defaults("R1 defaults after power-up reset");
      expect_out("R3 only processor and peripheral released", S_DOM, 32'h03);
      expect_out("R2 main PLL reset released", S_MAIN, 1);
      settle();

      // R11 plain configuration registers
      wr_reg(4'd5, 16'h00A5);
      wr_reg(4'd4, 16'h0009);
      wr_reg(4'd6, 16'h013C);
      wr_reg(4'd7, 16'h0005);
      expect_out("R11 gpio enables", S_GPIO, 32'hA5);
      expect_out("R11 front-end clocks", S_FE, 32'h9);
      expect_out("R11 display data", S_DOUT, 32'h3C);
      expect_out("R11 display drive", S_DRV, 1);
      expect_out("R11 processor divider", S_PDIV, 5);
      settle();

      // R3 domain release, then re-hold one, auto bits stay
      wr_reg(4'd3, 16'h003C);
      expect_out("R3 software domain release", S_DOM, 32'h3F);
      settle();
      wr_reg(4'd3, 16'h0010);
      expect_out("R3 rehold keeps auto domains", S_DOM, 32'h13);
      settle();

      // R9 divider release without lock
      wr_reg(4'd0, 16'h0002);
      expect_out("R9 release without lock sets error", S_ERR, 1);
      expect_out("R9 release without lock ignored", S_DIV, 0);
      settle();

      // R5 rate while down, R8 output rate before lock ignored
      wr_reg(4'd1, 16'h0042);
      wr_reg(4'd2, 16'h0055);
      expect_out("R5 rate accepted while powered down", S_RATE, 32'h42);
      expect_out("R8 output rate ignored before lock", S_ORATE, 0);
      settle();

      // R6 power up
      wr_reg(4'd0, 16'h0001);
      expect_out("R6 PLL powered up", S_PD, 0);
      expect_out("R6 dividers still held", S_DIV, 0);
      settle();
      wr_reg(4'd1, 16'h0077);
      expect_out("R5 rate ignored while powered up", S_RATE, 32'h42);
      settle();
      wr_reg(4'd0, 16'h0004);
      expect_out("R10 external release ignored before dividers", S_EXT, 0);
      settle();

      // R7 short lock pulse
      @(negedge clk);
      pll_lock = 1'b1;
      idle(10);
      pll_lock = 1'b0;
      idle(4);
      expect_out("R7 short lock not qualified", S_LOCK, 0);
      settle();

      // R7 sustained lock: sync 2 plus count 16
      pll_lock = 1'b1;
      idle(12);
      expect_out("R7 lock not yet qualified", S_LOCK, 0);
      settle();
      idle(10);
      expect_out("R7 lock qualified", S_LOCK, 1);
      settle();

      // R8 output rate accepted
      wr_reg(4'd2, 16'h0019);
      expect_out("R8 output rate accepted when locked", S_ORATE, 32'h19);
      settle();

      // R9 divider release with lock
      wr_reg(4'd0, 16'h0002);
      expect_out("R9 dividers released", S_DIV, 1);
      expect_out("R9 error stays sticky", S_ERR, 1);
      settle();
      wr_reg(4'd2, 16'h0066);
      expect_out("R8 output rate ignored after release", S_ORATE, 32'h19);
      settle();

      // R10 external release
      wr_reg(4'd0, 16'h0004);
      expect_out("R10 external resets released", S_EXT, 32'h3);
      settle();

      // General reset colliding with a write: R1, R2
      @(negedge clk);
      reg_wr    = 1'b1;
      reg_addr  = 4'd5;
      reg_wdata = 16'h00FF;
      sys_rst_n = 1'b0;
      @(negedge clk);
      reg_wr = 1'b0;
      expect_out("R2 main PLL untouched by general reset", S_MAIN, 1);
      expect_out("R4 dom resets low during general reset", S_DOM, 0);
      settle();
      sys_rst_n = 1'b1;
      idle(8);
      check_defaults("R1 defaults after general reset with write");
      expect_out("R3 auto domains after general reset", S_DOM, 32'h03);
      expect_out("R7 lock cleared after reset", S_LOCK, 0);
      settle();

      // Second power-up reset
      por_n = 1'b0;
      idle(2);
      expect_out("R2 main PLL reset by power-up reset", S_MAIN, 0);
      settle();
      por_n = 1'b1;
      idle(8);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule